// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that sits next to a 16-bit up/down timer. The timer supplies its live count, a tick enable and markers for its TOP and BOTTOM values. The channel holds a compare value and checks it against the count on every tick. On a match it sets a sticky flag and moves an internal waveform level according to a 2-bit action field.

In PWM modes a write from the processor side lands in a shadow buffer. The active compare value then changes only at the chosen turning point of the counter, so no pulse is cut short. In non-PWM modes a write goes straight to the active value. Software can fire the pin action without a real match by using a force strobe. A write to the counter suppresses the match on the tick that follows it, so software can preload the counter equal to the compare value without causing an event.

Top module: `occ_top`

## Requirements
- R1: A synchronous active-high reset clears the active compare value, the buffer, the match flag and the waveform level to zero.
- R2: With `is_pwm` low, a compare write loads both the active value and the buffer, and both show the new value one cycle later.
- R3: With `is_pwm` high, a compare write loads only the buffer. The active value takes the buffer contents only on a cycle with `tick` high and the update point asserted. The update point is `at_top` when `upd_sel`=1 and `at_bottom` when `upd_sel`=0.
- R4: A match is a cycle with `tick` high, `cnt` equal to the active value and no pending block. A match sets `match_flag` on the next cycle.
- R5: The action field `com` is encoded as follows: 2'b00 holds the level, 2'b01 toggles it, 2'b10 drives it to 0 and 2'b11 drives it to 1. The action is applied on a match, and the new level appears one cycle later.
- R6: `force_strb` applies the same `com` action as a match but leaves `match_flag` unchanged. It does this only when `is_pwm` is low; when `is_pwm` is high the strobe has no effect.
- R7: A `cnt_wr` pulse blocks a match on the first tick in a later cycle. This holds however many idle cycles pass before that tick. The tick after that one matches normally.
- R8: `flag_clr` clears `match_flag`. If a match happens in the same cycle, the flag stays set.
- R9: `com` is not buffered. `oc_en` is high whenever `com` is not 2'b00, and it follows `com` in the same cycle. Changing `is_pwm` leaves the waveform level unchanged.
- R10: With `tick` low, a count equal to the compare value causes no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick enable |
| cnt | input | 16 | Live counter value |
| cnt_wr | input | 1 | Pulse: software wrote the counter |
| is_pwm | input | 1 | 1 = PWM waveform mode (buffered compare) |
| upd_sel | input | 1 | Buffer transfer point: 1 = TOP, 0 = BOTTOM |
| at_top | input | 1 | Counter is at TOP |
| at_bottom | input | 1 | Counter is at BOTTOM |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | Compare value write data |
| com | input | 2 | Compare output action field |
| force_strb | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | Write-one clear of the match flag |
| cmp_val | output | 16 | Active compare value |
| buf_val | output | 16 | Shadow buffer contents |
| match_flag | output | 1 | Sticky match flag |
| oc_level | output | 1 | Internal waveform level |
| oc_en | output | 1 | Pin driven by the channel |

## Verification
The bench checks the buffer transfer against the wrong turning point and against a turning point without a tick. A design that copied the buffer too early would change the active value mid-period. It also writes the counter and then ticks at an equal count, both right away and after idle cycles with the timer stopped. A design whose block expires on the clock rather than on the tick would raise a match there. Clear and match are driven in the same cycle to show that the set has priority over the clear. The force strobe is tested in both mode classes. A design that let the force set the flag, or acted on it in PWM mode, would move the flag or the level where neither should change.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    COM_OFF = 2'b00,
    COM_TGL = 2'b01,
    COM_CLR = 2'b10,
    COM_SET = 2'b11
  } com_e;

  function automatic logic com_apply(input com_e mode, input logic cur);
    case (mode)
      COM_TGL: com_apply = ~cur;
      COM_CLR: com_apply = 1'b0;
      COM_SET: com_apply = 1'b1;
      default: com_apply = cur;
    endcase
  endfunction
endpackage

// File: rtl/occ_cmp_store.sv
module occ_cmp_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         is_pwm,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         tick,
  input  logic         upd_sel,
  input  logic         at_top,
  input  logic         at_bottom,
  output logic [W-1:0] act_q,
  output logic [W-1:0] buf_q,
  output logic         xfer
);
  logic upd_pt;
  assign upd_pt = upd_sel ? at_top : at_bottom;
  assign xfer   = is_pwm && tick && upd_pt;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      buf_q <= '0;
    end else begin
      if (cmp_wr) buf_q <= cmp_wdata;
      if (cmp_wr && !is_pwm) act_q <= cmp_wdata;
      else if (xfer)         act_q <= buf_q;
    end
  end

  // R2: active value moves only on a direct write or a transfer
  a_r2_active_hold: assert property (@(posedge clk) disable iff (rst)
    (!cmp_wr && !xfer) |=> $stable(act_q));

  // R3: buffered write leaves the active value alone
  a_r3_buffered_write: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && cmp_wr && !xfer) |=> $stable(act_q));
endmodule

// File: rtl/occ_match.sv
module occ_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         cnt_wr,
  input  logic         flag_clr,
  output logic         hit,
  output logic         flag_q
);
  logic block_q;

  assign hit = tick && (cnt == cmp) && !block_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      block_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (cnt_wr)    block_q <= 1'b1;
      else if (tick) block_q <= 1'b0;
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  // R7: a counter write suppresses the match of the next cycle
  a_r7_write_blocks: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> !hit);

  // R4: a match always leaves the flag set
  a_r4_flag_set: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);

  // R8: set has priority over clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (hit && flag_clr) |=> flag_q);
endmodule

// File: rtl/occ_wave.sv
module occ_wave
  import occ_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  com_e com,
  input  logic hit,
  input  logic force_strb,
  input  logic is_pwm,
  output logic level_q,
  output logic oc_en
);
  logic ev;
  assign ev    = hit || (force_strb && !is_pwm);
  assign oc_en = (com != COM_OFF);

  always_ff @(posedge clk) begin
    if (rst)     level_q <= 1'b0;
    else if (ev) level_q <= com_apply(com, level_q);
  end

  // R5: disconnected action never moves the level
  a_r5_off_holds: assert property (@(posedge clk) disable iff (rst)
    (com == COM_OFF) |=> $stable(level_q));

  // R6: force is ignored in PWM modes
  a_r6_pwm_force_ignored: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && force_strb && !hit) |=> $stable(level_q));
endmodule

// File: rtl/occ_top.sv
module occ_top
  import occ_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         cnt_wr,
  input  logic         is_pwm,
  input  logic         upd_sel,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic [1:0]   com,
  input  logic         force_strb,
  input  logic         flag_clr,
  output logic [W-1:0] cmp_val,
  output logic [W-1:0] buf_val,
  output logic         match_flag,
  output logic         oc_level,
  output logic         oc_en
);
  logic hit;
  logic xfer;
  com_e com_m;
  assign com_m = com_e'(com);

  occ_cmp_store #(.W(W)) u_store (
    .clk(clk), .rst(rst), .is_pwm(is_pwm), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .tick(tick), .upd_sel(upd_sel),
    .at_top(at_top), .at_bottom(at_bottom),
    .act_q(cmp_val), .buf_q(buf_val), .xfer(xfer)
  );

  occ_match #(.W(W)) u_match (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cmp(cmp_val),
    .cnt_wr(cnt_wr), .flag_clr(flag_clr), .hit(hit), .flag_q(match_flag)
  );

  occ_wave u_wave (
    .clk(clk), .rst(rst), .com(com_m), .hit(hit),
    .force_strb(force_strb), .is_pwm(is_pwm),
    .level_q(oc_level), .oc_en(oc_en)
  );

  // R6: a forced event never raises the flag
  a_r6_force_no_flag: assert property (@(posedge clk) disable iff (rst)
    (force_strb && !hit && !match_flag) |=> !match_flag);

  // R1: state is clear the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cmp_val == '0 && buf_val == '0 && !match_flag && !oc_level));
endmodule

// File: tb/occ_top_tb.sv
module occ_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        tick, cnt_wr, is_pwm, upd_sel, at_top, at_bottom;
  logic        cmp_wr, force_strb, flag_clr;
  logic [15:0] cnt, cmp_wdata;
  logic [1:0]  com;
  logic [15:0] cmp_val, buf_val;
  logic        match_flag, oc_level, oc_en;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  occ_top #(.W(16)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cnt_wr(cnt_wr),
    .is_pwm(is_pwm), .upd_sel(upd_sel), .at_top(at_top), .at_bottom(at_bottom),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .com(com), .force_strb(force_strb),
    .flag_clr(flag_clr), .cmp_val(cmp_val), .buf_val(buf_val),
    .match_flag(match_flag), .oc_level(oc_level), .oc_en(oc_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(); cyc(); rst = 1'b0;
    chk("R1 cmp", cmp_val, 0);
    chk("R1 buf", buf_val, 0);
    chk("R1 flag", match_flag, 0);
    chk("R1 level", oc_level, 0);
  endtask

  task automatic t_direct_write();
    is_pwm = 1'b0;
    cmp_wr = 1'b1; cmp_wdata = 16'h1234; cyc(); cmp_wr = 1'b0;
    chk("R2 active", cmp_val, 16'h1234);
    chk("R2 buffer", buf_val, 16'h1234);
  endtask

  task automatic t_match();
    com = 2'b01; cnt = 16'h1234; tick = 1'b1; cyc(); tick = 1'b0;
    chk("R4 flag", match_flag, 1);
    chk("R5 toggle", oc_level, 1);
    cnt = 16'h1235; tick = 1'b1; cyc(); tick = 1'b0;
    chk("R4 mismatch level", oc_level, 1);
    cnt = 16'h1234; cyc(); cyc();
    chk("R10 no tick", oc_level, 1);
  endtask

  task automatic t_flag();
    clr_flag();
    chk("R8 clear", match_flag, 0);
    cnt = 16'h1234; tick = 1'b1; flag_clr = 1'b1; cyc();
    tick = 1'b0; flag_clr = 1'b0;
    chk("R8 set wins", match_flag, 1);
    chk("R5 toggle back", oc_level, 0);
    clr_flag();
  endtask

  task automatic t_com();
    com = 2'b11; tick = 1'b1; cyc(); chk("R5 set", oc_level, 1);
    com = 2'b10; cyc(); chk("R5 clear", oc_level, 0);
    com = 2'b11; cyc(); chk("R5 set again", oc_level, 1);
    tick = 1'b0;
    com = 2'b00; #1;
    chk("R9 oc_en immediate off", oc_en, 0);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R5 off holds", oc_level, 1);
    com = 2'b10; #1;
    chk("R9 oc_en immediate on", oc_en, 1);
    clr_flag();
  endtask

  task automatic t_force();
    cnt = 16'h0000;
    com = 2'b10; force_strb = 1'b1; cyc(); force_strb = 1'b0;
    chk("R6 force acts", oc_level, 0);
    chk("R6 force no flag", match_flag, 0);
    is_pwm = 1'b1; com = 2'b11; force_strb = 1'b1; cyc(); force_strb = 1'b0;
    chk("R6 pwm force ignored", oc_level, 0);
    is_pwm = 1'b0; force_strb = 1'b1; cyc(); force_strb = 1'b0;
    chk("R6 force set", oc_level, 1);
    is_pwm = 1'b1; cyc(); cyc();
    chk("R9 level across mode", oc_level, 1);
    is_pwm = 1'b0; cyc();
    chk("R9 level back", oc_level, 1);
  endtask

  task automatic t_block();
    cnt = 16'h1234; cnt_wr = 1'b1; cyc(); cnt_wr = 1'b0;
    com = 2'b10; tick = 1'b1; cyc(); tick = 1'b0;
    chk("R7 blocked flag", match_flag, 0);
    chk("R7 blocked level", oc_level, 1);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R7 next tick flag", match_flag, 1);
    chk("R7 next tick level", oc_level, 0);
    clr_flag();
    com = 2'b11; cnt_wr = 1'b1; cyc(); cnt_wr = 1'b0;
    cyc(); cyc(); cyc();
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R7 stopped blocked", match_flag, 0);
    chk("R7 stopped level", oc_level, 0);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R7 stopped then match", match_flag, 1);
    chk("R7 stopped then level", oc_level, 1);
    clr_flag();
  endtask

  task automatic t_buffer();
    cnt = 16'h0000; is_pwm = 1'b1; upd_sel = 1'b1;
    cmp_wr = 1'b1; cmp_wdata = 16'h0100; cyc(); cmp_wr = 1'b0;
    chk("R3 buffer loaded", buf_val, 16'h0100);
    chk("R3 active held", cmp_val, 16'h1234);
    tick = 1'b1; at_bottom = 1'b1; cyc(); tick = 1'b0; at_bottom = 1'b0;
    chk("R3 wrong point", cmp_val, 16'h1234);
    at_top = 1'b1; cyc(); at_top = 1'b0;
    chk("R3 no tick", cmp_val, 16'h1234);
    tick = 1'b1; at_top = 1'b1; cyc(); tick = 1'b0; at_top = 1'b0;
    chk("R3 top transfer", cmp_val, 16'h0100);
    upd_sel = 1'b0;
    cmp_wr = 1'b1; cmp_wdata = 16'h0200; cyc(); cmp_wr = 1'b0;
    tick = 1'b1; at_top = 1'b1; cyc(); tick = 1'b0; at_top = 1'b0;
    chk("R3 bottom sel ignores top", cmp_val, 16'h0100);
    tick = 1'b1; at_bottom = 1'b1; cyc(); tick = 1'b0; at_bottom = 1'b0;
    chk("R3 bottom transfer", cmp_val, 16'h0200);
    is_pwm = 1'b0;
    cmp_wr = 1'b1; cmp_wdata = 16'h00FF; cyc(); cmp_wr = 1'b0;
    chk("R2 direct after pwm", cmp_val, 16'h00FF);
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = 0; cnt = 0; cnt_wr = 0; is_pwm = 0; upd_sel = 0;
    at_top = 0; at_bottom = 0; cmp_wr = 0; cmp_wdata = 0; com = 0;
    force_strb = 0; flag_clr = 0;
    cyc();
    t_reset();
    t_direct_write();
    t_match();
    t_flag();
    t_com();
    t_force();
    t_block();
    t_buffer();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule